// File: doc/BRIEF.md
# Interrupt Entry Controller

This block sits next to a small 32-bit processor core and decides, cycle by cycle, whether one of three kinds of request is accepted. The request can be a reset, a non-maskable interrupt (NMI) or one of six maskable sources. Each request line is watched for rising edges, and every edge sets a sticky pending bit. Each cycle the block looks at the pending bits together with the core's current status word and accepts at most one request.

When it accepts a request, it raises a redirect strobe for one cycle. In the same cycle it presents the new program counter and the status word the core must load. At the following clock edge it updates its own cause register and the saved-context registers. The core is modelled only by its PC and status-word inputs. The core is expected to load the presented target and status word at the edge that ends the strobe.

Status-word bits used by the block: bit 7 is the NMI-in-progress flag (NP), bit 6 is the exception-in-progress flag (EP), and bit 5 is the interrupt-disable flag (ID).

Top module: `irq_entry_ctrl`

## Requirements
- R1: A pending reset request wins over every other request. It redirects to address 0 with next status word 0x20, sets the cause register to 0 at the following edge, and discards all other pending requests except edges sampled at that same edge.
- R2: Each request line is captured on its rising edge into a sticky pending bit. A line held high produces exactly one request. A request sampled at clock edge k can be accepted at the earliest in the cycle that follows edge k.
- R3: A pending NMI is accepted only while status bit 7 is clear. When accepted, the target is 0x10 and the next status word equals the current one with bits 7 and 5 set and bit 6 cleared.
- R4: On NMI entry, PC is saved to the NMI PC register and the status word to the NMI status register. The cause register becomes its lower 16 bits ORed with 0x10, with the upper 16 bits cleared.
- R5: NMI edges that arrive while bit 7 is set collapse into a single pending request. That request is retried every cycle and is accepted exactly once after bit 7 clears.
- R6: Maskable requests are not accepted while status bit 7 or bit 5 is set. They stay pending until both bits are clear.
- R7: On maskable entry, PC is saved to the interrupt PC register and the status word to the interrupt status register. The next status word has bit 5 set and bit 6 cleared. The cause register keeps its upper 16 bits and takes the source vector in its lower 16 bits.
- R8: Maskable source n (0 to 5) uses vector 0x80 + 0x10·n. Among simultaneous pending sources the lowest n wins. A pending NMI that is allowed wins over any maskable source.
- R9: The redirect strobe is high for exactly one cycle per accepted request. An accepted request's pending bit clears, but a new edge on the same line sampled at that edge stays pending.
- R10: After reset, the strobe is low and the cause and saved-context registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rst_req_i | input | 1 | Reset request line (edge captured) |
| nmi_req_i | input | 1 | Non-maskable request line (edge captured) |
| irq_req_i | input | 6 | Maskable request lines, bit n is source n |
| pc_i | input | 32 | Current PC of the core |
| psw_i | input | 32 | Current status word of the core |
| redirect_o | output | 1 | One-cycle strobe: a request is accepted this cycle |
| target_pc_o | output | 32 | New PC while the strobe is high, else 0 |
| psw_nxt_o | output | 32 | Status word to load; equals psw_i when idle |
| ecr_o | output | 32 | Cause register |
| fepc_o | output | 32 | PC saved on NMI entry |
| fepsw_o | output | 32 | Status word saved on NMI entry |
| eipc_o | output | 32 | PC saved on maskable entry |
| eipsw_o | output | 32 | Status word saved on maskable entry |

## Verification
The hardest case to reach from the ports is a fresh NMI edge that lands exactly at the edge where an earlier, blocked NMI is finally accepted. In that case the pending bit must survive the clear, which yields a second entry. The stimulus first blocks an NMI with bit 7 set and drops the line for one cycle. It then clears bit 7 and raises the line again in the same cycle, and counts the NMI entries that follow. Random traffic with frequent status-word changes covers blocked maskable requests, priority races and collapsed NMI bursts, all checked against a cycle model kept in the bench.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_RST  = 2'd1,
    TAKE_NMI  = 2'd2,
    TAKE_MSK  = 2'd3
  } take_e;

  // status word flag positions
  localparam int unsigned PSW_NP_BIT = 7;
  localparam int unsigned PSW_EP_BIT = 6;
  localparam int unsigned PSW_ID_BIT = 5;

  // pending slot layout: reset, nmi, then maskable sources
  localparam int unsigned SLOT_RST  = 0;
  localparam int unsigned SLOT_NMI  = 1;
  localparam int unsigned SLOT_IRQ0 = 2;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/irq_pend_capture.sv
module irq_pend_capture #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic         clr_all_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic [W-1:0] rise;

  for (genvar g = 0; g < W; g++) begin : g_slot
    always_comb begin
      rise[g] = req_i[g] & ~prev_q[g];
      if (clr_all_i) begin
        pend_d[g] = rise[g];
      end else begin
        pend_d[g] = (pend_q[g] & ~clr_i[g]) | rise[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        pend_q[g] <= pend_d[g];
      end
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N    = 6,
  parameter int unsigned SELW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [SELW-1:0] sel_o
);

  always_comb begin
    any_o = 1'b0;
    sel_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        sel_o = SELW'(i);
      end
    end
  end

endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_entry_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  take_e           take_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] psw_i,
  input  logic [XLEN-1:0] ecr_nxt_i,
  output logic [XLEN-1:0] ecr_o,
  output logic [XLEN-1:0] fepc_o,
  output logic [XLEN-1:0] fepsw_o,
  output logic [XLEN-1:0] eipc_o,
  output logic [XLEN-1:0] eipsw_o
);

  logic ecr_en;
  logic nmi_en;
  logic msk_en;

  always_comb begin
    ecr_en = (take_i != TAKE_NONE);
    nmi_en = (take_i == TAKE_NMI);
    msk_en = (take_i == TAKE_MSK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecr_o   <= '0;
      fepc_o  <= '0;
      fepsw_o <= '0;
      eipc_o  <= '0;
      eipsw_o <= '0;
    end else begin
      if (ecr_en) ecr_o <= ecr_nxt_i;
      if (nmi_en) begin
        fepc_o  <= pc_i;
        fepsw_o <= psw_i;
      end
      if (msk_en) begin
        eipc_o  <= pc_i;
        eipsw_o <= psw_i;
      end
    end
  end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter int unsigned     NUM_IRQ      = 6,
  parameter logic [XLEN-1:0] NMI_VEC      = 32'h0000_0010,
  parameter logic [XLEN-1:0] IRQ_VEC_BASE = 32'h0000_0080,
  parameter logic [XLEN-1:0] IRQ_VEC_STEP = 32'h0000_0010,
  parameter logic [XLEN-1:0] RST_PSW      = 32'h0000_0020
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_req_i,
  input  logic               nmi_req_i,
  input  logic [NUM_IRQ-1:0] irq_req_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    psw_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    target_pc_o,
  output logic [XLEN-1:0]    psw_nxt_o,
  output logic [XLEN-1:0]    ecr_o,
  output logic [XLEN-1:0]    fepc_o,
  output logic [XLEN-1:0]    fepsw_o,
  output logic [XLEN-1:0]    eipc_o,
  output logic [XLEN-1:0]    eipsw_o
);

  localparam int unsigned NSLOT = NUM_IRQ + 2;
  localparam int unsigned SELW  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int unsigned HALF  = XLEN / 2;

  logic             rst_s;
  logic [NSLOT-1:0] req_all;
  logic [NSLOT-1:0] pend;
  logic [NSLOT-1:0] clr;
  logic             clr_all;
  logic             msk_any;
  logic [SELW-1:0]  msk_sel;
  logic             nmi_ok;
  logic             msk_ok;
  take_e            take;
  logic [XLEN-1:0]  msk_vec;
  logic [XLEN-1:0]  ecr_nxt;
  logic [XLEN-1:0]  irq_vec [NUM_IRQ];

  irq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s)
  );

  assign req_all = {irq_req_i, nmi_req_i, rst_req_i};

  irq_pend_capture #(.W(NSLOT)) u_capture (
    .clk       (clk),
    .rst_n     (rst_s),
    .req_i     (req_all),
    .clr_all_i (clr_all),
    .clr_i     (clr),
    .pend_o    (pend)
  );

  irq_prio_pick #(.N(NUM_IRQ), .SELW(SELW)) u_pick (
    .req_i (pend[NSLOT-1:SLOT_IRQ0]),
    .any_o (msk_any),
    .sel_o (msk_sel)
  );

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_vec
    localparam logic [XLEN-1:0] VEC = IRQ_VEC_BASE + IRQ_VEC_STEP * XLEN'(g);
    assign irq_vec[g] = VEC;
  end

  assign msk_vec = irq_vec[msk_sel];

  // acceptance decision
  always_comb begin
    nmi_ok = ~psw_i[PSW_NP_BIT];
    msk_ok = ~psw_i[PSW_NP_BIT] & ~psw_i[PSW_ID_BIT];
    if (pend[SLOT_RST]) begin
      take = TAKE_RST;
    end else if (pend[SLOT_NMI] && nmi_ok) begin
      take = TAKE_NMI;
    end else if (msk_any && msk_ok) begin
      take = TAKE_MSK;
    end else begin
      take = TAKE_NONE;
    end
  end

  // pending clear
  always_comb begin
    clr     = '0;
    clr_all = (take == TAKE_RST);
    if (take == TAKE_NMI) clr[SLOT_NMI] = 1'b1;
    if (take == TAKE_MSK) clr[SLOT_IRQ0 + int'(msk_sel)] = 1'b1;
  end

  // redirect outputs and next cause value
  always_comb begin
    redirect_o  = (take != TAKE_NONE);
    target_pc_o = '0;
    psw_nxt_o   = psw_i;
    ecr_nxt     = ecr_o;
    unique case (take)
      TAKE_RST: begin
        target_pc_o = '0;
        psw_nxt_o   = RST_PSW;
        ecr_nxt     = '0;
      end
      TAKE_NMI: begin
        target_pc_o = NMI_VEC;
        psw_nxt_o[PSW_NP_BIT] = 1'b1;
        psw_nxt_o[PSW_ID_BIT] = 1'b1;
        psw_nxt_o[PSW_EP_BIT] = 1'b0;
        ecr_nxt = {{(XLEN-HALF){1'b0}}, ecr_o[HALF-1:0] | NMI_VEC[HALF-1:0]};
      end
      TAKE_MSK: begin
        target_pc_o = msk_vec;
        psw_nxt_o[PSW_ID_BIT] = 1'b1;
        psw_nxt_o[PSW_EP_BIT] = 1'b0;
        ecr_nxt = {ecr_o[XLEN-1:HALF], msk_vec[HALF-1:0]};
      end
      default: begin
        target_pc_o = '0;
      end
    endcase
  end

  irq_ctx_regs #(.XLEN(XLEN)) u_ctx (
    .clk       (clk),
    .rst_n     (rst_s),
    .take_i    (take),
    .pc_i      (pc_i),
    .psw_i     (psw_i),
    .ecr_nxt_i (ecr_nxt),
    .ecr_o     (ecr_o),
    .fepc_o    (fepc_o),
    .fepsw_o   (fepsw_o),
    .eipc_o    (eipc_o),
    .eipsw_o   (eipsw_o)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter int unsigned     NSLOT        = 8,
  parameter logic [XLEN-1:0] NMI_VEC      = 32'h10,
  parameter logic [XLEN-1:0] IRQ_VEC_BASE = 32'h80,
  parameter logic [XLEN-1:0] RST_PSW      = 32'h20
) (
  input logic             clk,
  input logic             rst_ok,
  input logic [NSLOT-1:0] pend,
  input logic [XLEN-1:0]  pc_i,
  input logic [XLEN-1:0]  psw_i,
  input logic             redirect_o,
  input logic [XLEN-1:0]  target_pc_o,
  input logic [XLEN-1:0]  psw_nxt_o,
  input logic [XLEN-1:0]  ecr_o,
  input logic [XLEN-1:0]  fepc_o,
  input logic [XLEN-1:0]  fepsw_o
);

  localparam int unsigned HALF = XLEN / 2;

  a_r1_rst_wins: assert property (@(posedge clk) disable iff (!rst_ok)
    pend[SLOT_RST] |-> (redirect_o && target_pc_o == '0 && psw_nxt_o == RST_PSW));

  a_r1_ecr_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    pend[SLOT_RST] |=> (ecr_o == '0));

  a_r3_nmi_gate: assert property (@(posedge clk) disable iff (!rst_ok)
    (!pend[SLOT_RST] && psw_i[PSW_NP_BIT]) |-> !redirect_o);

  a_r4_nmi_save: assert property (@(posedge clk) disable iff (!rst_ok)
    (redirect_o && !pend[SLOT_RST] && target_pc_o == NMI_VEC)
      |=> (fepc_o == $past(pc_i) && fepsw_o == $past(psw_i)));

  a_r6_msk_gate: assert property (@(posedge clk) disable iff (!rst_ok)
    (psw_i[PSW_ID_BIT] && !pend[SLOT_RST] && !pend[SLOT_NMI]) |-> !redirect_o);

  a_r7_ecr_upper: assert property (@(posedge clk) disable iff (!rst_ok)
    (redirect_o && !pend[SLOT_RST] && target_pc_o >= IRQ_VEC_BASE)
      |=> $stable(ecr_o[XLEN-1:HALF]));

endmodule

bind irq_entry_ctrl irq_entry_chk #(
  .XLEN         (XLEN),
  .NSLOT        (NUM_IRQ + 2),
  .NMI_VEC      (NMI_VEC),
  .IRQ_VEC_BASE (IRQ_VEC_BASE),
  .RST_PSW      (RST_PSW)
) u_chk (
  .clk         (clk),
  .rst_ok      (rst_s),
  .pend        (pend),
  .pc_i        (pc_i),
  .psw_i       (psw_i),
  .redirect_o  (redirect_o),
  .target_pc_o (target_pc_o),
  .psw_nxt_o   (psw_nxt_o),
  .ecr_o       (ecr_o),
  .fepc_o      (fepc_o),
  .fepsw_o     (fepsw_o)
);

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 6;
  localparam int NS = NIRQ + 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            rst_req;
  logic            nmi_req;
  logic [NIRQ-1:0] irq_req;
  logic [31:0]     pc;
  logic [31:0]     psw;
  logic            redirect;
  logic [31:0]     target, psw_nxt, ecr, fepc, fepsw, eipc, eipsw;

  irq_entry_ctrl i_irq_entry_ctrl (
    .clk (clk), .rst_n (rst_n), .rst_req_i (rst_req), .nmi_req_i (nmi_req),
    .irq_req_i (irq_req), .pc_i (pc), .psw_i (psw), .redirect_o (redirect),
    .target_pc_o (target), .psw_nxt_o (psw_nxt), .ecr_o (ecr), .fepc_o (fepc),
    .fepsw_o (fepsw), .eipc_o (eipc), .eipsw_o (eipsw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int nmi_takes = 0;
  int msk_takes = 0;
  int cycles = 0;

  // stimulus state
  logic            b_rst, b_nmi;
  logic [NIRQ-1:0] b_irq;
  logic [31:0]     core_pc, core_psw;

  // bench model state
  logic [NS-1:0] m_prev, m_pend;
  logic [31:0]   m_ecr, m_fepc, m_fepsw, m_eipc, m_eipsw;
  int            last_kind;
  int            last_target;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // kind: 0 none, 1 reset, 2 nmi, 3 maskable
  function automatic int pick_kind(input logic [NS-1:0] p, input logic [31:0] s);
    if (p[0]) return 1;
    if (p[1] && !s[7]) return 2;
    if ((p[NS-1:2] != '0) && !s[7] && !s[5]) return 3;
    return 0;
  endfunction

  function automatic int lowest_src(input logic [NS-1:0] p);
    for (int i = 0; i < NIRQ; i++) if (p[i+2]) return i;
    return 0;
  endfunction

  task automatic cycle();
    int          kind, sel;
    logic [31:0] e_tgt, e_psw;
    logic [NS-1:0] lines, rise, clrv;
    @(negedge clk);
    rst_req = b_rst; nmi_req = b_nmi; irq_req = b_irq;
    pc = core_pc; psw = core_psw;
    #1;
    cycles++;
    kind = pick_kind(m_pend, core_psw);
    sel  = lowest_src(m_pend);
    e_tgt = 32'h0; e_psw = core_psw;
    if (kind == 1) begin e_tgt = 32'h0; e_psw = 32'h20; end
    if (kind == 2) begin e_tgt = 32'h10; e_psw = (core_psw | 32'hA0) & ~32'h40; end
    if (kind == 3) begin e_tgt = 32'h80 + 32'h10 * sel; e_psw = (core_psw | 32'h20) & ~32'h40; end
    chk("R9 strobe", {31'b0, redirect}, {31'b0, kind != 0});
    if (kind == 1) begin chk("R1 target", target, e_tgt); chk("R1 psw", psw_nxt, e_psw); end
    if (kind == 2) begin chk("R3 target", target, e_tgt); chk("R3 psw", psw_nxt, e_psw); end
    if (kind == 3) begin chk("R8 target", target, e_tgt); chk("R7 psw", psw_nxt, e_psw); end
    chk("R4/R7 ecr", ecr, m_ecr);
    chk("R4 fepc", fepc, m_fepc);
    chk("R4 fepsw", fepsw, m_fepsw);
    chk("R7 eipc", eipc, m_eipc);
    chk("R7 eipsw", eipsw, m_eipsw);
    last_kind = kind; last_target = int'(e_tgt);
    if (kind == 2) nmi_takes++;
    if (kind == 3) msk_takes++;
    // model update for the coming edge
    lines = {b_irq, b_nmi, b_rst};
    rise  = lines & ~m_prev;
    clrv  = '0;
    if (kind == 2) clrv[1] = 1'b1;
    if (kind == 3) clrv[sel+2] = 1'b1;
    m_pend = (kind == 1) ? rise : ((m_pend & ~clrv) | rise);
    m_prev = lines;
    if (kind == 1) m_ecr = 32'h0;
    if (kind == 2) begin
      m_ecr = {16'h0, m_ecr[15:0] | 16'h0010};
      m_fepc = core_pc; m_fepsw = core_psw;
    end
    if (kind == 3) begin
      m_ecr = {m_ecr[31:16], e_tgt[15:0]};
      m_eipc = core_pc; m_eipsw = core_psw;
    end
    if (kind != 0) begin core_pc = e_tgt; core_psw = e_psw; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rst_req = 0; nmi_req = 0; irq_req = '0; pc = '0; psw = '0;
    b_rst = 0; b_nmi = 0; b_irq = '0; core_pc = 32'h1000; core_psw = 32'h0;
    m_prev = '0; m_pend = '0;
    m_ecr = '0; m_fepc = '0; m_fepsw = '0; m_eipc = '0; m_eipsw = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);
    // R10: reset state
    chk("R10 strobe", {31'b0, redirect}, 32'h0);
    chk("R10 ecr", ecr, 32'h0);
    chk("R10 eipc", eipc, 32'h0);

    // R2: a held line gives one entry, taken the cycle after sampling
    t0 = msk_takes;
    b_irq = 6'b000100; cycle();
    chk("R2 not before edge", {31'b0, redirect}, 32'h0);
    cycle();
    chk("R2 taken after edge", target, 32'hA0);
    core_psw = 32'h0; idle(8);
    chk("R2 single entry", msk_takes - t0, 1);
    b_irq = '0; idle(2);

    // R6: ID set blocks, request survives
    core_psw = 32'h20; b_irq = 6'b001000; idle(6); b_irq = '0;
    chk("R6 blocked", msk_takes - t0, 1);
    core_psw = 32'h0; cycle();
    chk("R6 released", target, 32'hB0);
    core_psw = 32'h0; idle(2);

    // R8: simultaneous sources, lowest wins; NMI beats maskable
    b_irq = 6'b110010; b_nmi = 1; cycle();
    cycle();
    chk("R8 nmi first", target, 32'h10);
    core_psw = 32'h0; cycle();
    chk("R8 lowest src", target, 32'h90);
    core_psw = 32'h0; b_irq = '0; b_nmi = 0; idle(6);
    core_psw = 32'h0; idle(4);

    // R5: burst of NMIs under NP collapses to one
    t0 = nmi_takes; core_psw = 32'h80;
    for (int k = 0; k < 3; k++) begin b_nmi = 1; cycle(); b_nmi = 0; cycle(); end
    chk("R5 held", nmi_takes - t0, 0);
    core_psw = 32'h0; idle(4);
    chk("R5 one entry", nmi_takes - t0, 1);

    // R9: new edge on the edge where pending NMI is taken stays pending
    t0 = nmi_takes; core_psw = 32'h80;
    b_nmi = 1; cycle(); b_nmi = 0; cycle();
    core_psw = 32'h0; b_nmi = 1; cycle();
    chk("R9 first take", nmi_takes - t0, 1);
    idle(3);
    core_psw = 32'h0; idle(3);
    chk("R9 edge kept", nmi_takes - t0, 2);
    b_nmi = 0;

    // R1: reset beats everything and drops older pending
    core_psw = 32'h80; b_irq = 6'b000001; cycle(); b_irq = '0;
    b_rst = 1; b_nmi = 1; cycle();
    cycle();
    chk("R1 reset wins", {31'b0, redirect}, 32'h1);
    chk("R1 reset target", target, 32'h0);
    b_rst = 0; b_nmi = 0; idle(2);
    chk("R1 ecr cleared", ecr, m_ecr);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NIRQ; i++) if ($urandom_range(7) == 0) b_irq[i] = ~b_irq[i];
      if ($urandom_range(5) == 0) b_nmi = ~b_nmi;
      b_rst = ($urandom_range(79) == 0);
      if ($urandom_range(4) == 0) core_psw = core_psw & ~32'hA0;
      if ($urandom_range(15) == 0) core_psw = {$urandom()} & 32'hFFFF_FF7F;
      if ($urandom_range(3) == 0) core_pc = $urandom();
      cycle();
    end
    b_irq = '0; b_nmi = 0; b_rst = 0; idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule